// File: doc/BRIEF.md
# Shared Memory Port Arbiter with Age Ordering and Starvation Promotion

This block decides which of several bus masters may use a single shared external memory port. Each master raises its request line and waits for a one-hot grant. It keeps the grant until it pulses its own done line. Arbitration takes place only while the port is idle. Once a grant is issued, it stays fixed until the owning master reports completion.

A mode bit, written through a small configuration port, selects one of two policies. In age mode, the pending master that finished an access longest ago wins, so service rotates among the masters. In tiered mode, a pending master that has waited too long moves into an urgent tier, and the urgent tier always beats the normal tier. The wait limit is programmable for each master. One master, the host processor, is exempt: it never enters the urgent tier and competes only through age order. Inside each tier, ties are settled by age.

The mode bit and the wait limits are stored in registers selected by a configuration address. After reset, every wait limit holds the smallest useful value. Software should set the limits before it turns on tiered mode.

Top module: `mem_lru_arb`

## Requirements
- R1: `gnt_o` is one-hot or zero. A grant goes only to a master whose request was high in the idle cycle before it, and it appears at the first clock edge after that idle cycle.
- R2: With the mode bit at 0 (age mode), the pending master with the oldest completion wins. After reset, age order runs from master 0 (oldest) to master N-1 (newest).
- R3: With the mode bit at 1 (tiered mode), any pending master in the urgent tier beats every master in the normal tier. Ties inside a tier go to the older master.
- R4: A non-host master's wait count rises by one on each edge where its request is high and it is neither granted nor urgent. The master becomes urgent on the edge at which the count reaches its wait limit.
- R5: A grant stays unchanged until the granted master raises its done bit. A done bit from any other master is ignored. After completion there is one idle cycle, and then the next grant is issued.
- R6: The host master (index 0) never becomes urgent, however long it waits. A write to its wait-limit address has no effect on arbitration.
- R7: When a granted access completes, that master returns to the normal tier, its wait count clears, and it becomes the newest in age order.
- R8: After reset, there is no grant, every master is in the normal tier, every wait limit is 1, and the mode is age mode.
- R9: A mode write made while a grant is active leaves that grant untouched. The new mode is used at the next arbitration.
- R10: Configuration map: address 0, bit 0 is the mode bit. Address 1+i holds the wait limit of master i, using the full data width.
- R11: If a waiting master drops its request before it is granted, its wait count and urgent status clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | N_REQ | Request line for each master |
| done_i | input | N_REQ | Access-complete pulse for each master |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | CFG_AW | Configuration register select |
| cfg_wdata_i | input | TMO_W | Configuration write data |
| gnt_o | output | N_REQ | One-hot grant |

## Verification
On every cycle, the embedded properties check the following: grants are one-hot and go to a requester, a grant holds until its owner completes, a finisher moves to the newest age slot, completion clears the wait count, promotion happens only when the limit is reached, and the urgent tier wins in tiered mode. Some behaviours can only be shown by the directed scenarios, because each depends on a particular history: the exact rotation order, which master wins after a chosen wait pattern, the host staying in the normal tier while a peer is promoted, a mode write landing in the middle of a grant, and a cleared count preventing an early re-promotion.

// File: rtl/arb_pkg.sv
package arb_pkg;
  typedef enum logic {
    ARB_AGE  = 1'b0,
    ARB_TIER = 1'b1
  } arb_mode_e;

  localparam int unsigned TMO_RESET = 1;
endpackage

// File: rtl/arb_lru_order.sv
module arb_lru_order #(
  parameter int unsigned N_REQ = 4,
  localparam int unsigned RW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        upd_en_i,
  input  logic [RW-1:0]               upd_idx_i,
  output logic [N_REQ-1:0][RW-1:0]    rank_o
);
  localparam logic [RW-1:0] NEWEST = RW'(N_REQ - 1);

  logic [N_REQ-1:0][RW-1:0] rank_q;
  logic [RW-1:0]            fin_rank;

  assign fin_rank = rank_q[upd_idx_i];
  assign rank_o   = rank_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < N_REQ; i++) rank_q[i] <= RW'(i);
    end else if (upd_en_i) begin
      for (int i = 0; i < N_REQ; i++) begin
        if (RW'(i) == upd_idx_i)        rank_q[i] <= NEWEST;
        else if (rank_q[i] > fin_rank)  rank_q[i] <= rank_q[i] - RW'(1);
      end
    end
  end

  // R7: the master that just finished holds the newest slot
  a_r7_finisher_newest: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en_i |=> rank_q[$past(upd_idx_i)] == NEWEST);
endmodule

// File: rtl/arb_wait_ctr.sv
module arb_wait_ctr #(
  parameter int unsigned TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             gnt_i,
  input  logic             fin_i,
  input  logic [TMO_W-1:0] tmo_i,
  output logic             hi_o
);
  logic [TMO_W-1:0] cnt_q;
  logic             hi_q;
  logic             waiting;

  function automatic logic [TMO_W:0] cnt_next(input logic [TMO_W-1:0] c);
    return {1'b0, c} + {{TMO_W{1'b0}}, 1'b1};
  endfunction

  assign waiting = req_i && !gnt_i && !hi_q;
  assign hi_o    = hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else if (fin_i || !req_i) begin
      cnt_q <= '0;
      hi_q  <= 1'b0;
    end else if (waiting) begin
      if (cnt_q != '1) cnt_q <= cnt_next(cnt_q)[TMO_W-1:0];
      if (cnt_next(cnt_q) >= {1'b0, tmo_i}) hi_q <= 1'b1;
    end
  end

  // R7: completion empties the wait count and drops the urgent flag
  a_r7_clear_on_fin: assert property (@(posedge clk) disable iff (!rst_n)
    fin_i |=> (cnt_q == '0) && !hi_q);
  // R4: promotion happens only once the count has reached the limit
  a_r4_promote_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hi_q) |-> (cnt_q >= tmo_i) || (cnt_q == '1));
  // R11: a withdrawn request leaves no urgent state behind
  a_r11_withdraw: assert property (@(posedge clk) disable iff (!rst_n)
    !req_i |=> !hi_q);
endmodule

// File: rtl/arb_pick.sv
module arb_pick #(
  parameter int unsigned N_REQ = 4,
  localparam int unsigned RW = (N_REQ > 1) ? $clog2(N_REQ) : 1
) (
  input  logic [N_REQ-1:0]          pend_i,
  input  logic [N_REQ-1:0]          hi_i,
  input  logic                      tier_i,
  input  logic [N_REQ-1:0][RW-1:0]  rank_i,
  output logic [N_REQ-1:0]          win_o
);
  logic [N_REQ-1:0] urgent;
  logic [N_REQ-1:0] cand;

  function automatic logic [N_REQ-1:0] oldest(
    input logic [N_REQ-1:0]         c,
    input logic [N_REQ-1:0][RW-1:0] r);
    logic [N_REQ-1:0] oh;
    logic [RW-1:0]    best;
    logic             found;
    oh = '0; best = '0; found = 1'b0;
    for (int i = 0; i < N_REQ; i++) begin
      if (c[i] && (!found || r[i] < best)) begin
        oh    = '0;
        oh[i] = 1'b1;
        best  = r[i];
        found = 1'b1;
      end
    end
    return oh;
  endfunction

  assign urgent = pend_i & hi_i;
  assign cand   = (tier_i && (urgent != '0)) ? urgent : pend_i;
  assign win_o  = oldest(cand, rank_i);
endmodule

// File: rtl/mem_lru_arb.sv
module mem_lru_arb
  import arb_pkg::*;
#(
  parameter int unsigned N_REQ    = 4,
  parameter int unsigned TMO_W    = 8,
  parameter int unsigned HOST_IDX = 0,
  localparam int unsigned RW     = (N_REQ > 1) ? $clog2(N_REQ) : 1,
  localparam int unsigned CFG_AW = $clog2(N_REQ + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_REQ-1:0]  req_i,
  input  logic [N_REQ-1:0]  done_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [TMO_W-1:0]  cfg_wdata_i,
  output logic [N_REQ-1:0]  gnt_o
);
  arb_mode_e                   mode_q;
  logic [N_REQ-1:0][TMO_W-1:0] tmo_q;
  logic [N_REQ-1:0]            gnt_q;
  logic                        busy_q;
  logic [N_REQ-1:0]            hi;
  logic [N_REQ-1:0]            win;
  logic [N_REQ-1:0]            fin_vec;
  logic [N_REQ-1:0][RW-1:0]    rank;
  logic                        fin;
  logic                        start;
  logic [RW-1:0]               gnt_idx;

  function automatic logic [RW-1:0] oh_to_idx(input logic [N_REQ-1:0] oh);
    logic [RW-1:0] idx;
    idx = '0;
    for (int i = 0; i < N_REQ; i++) if (oh[i]) idx = RW'(i);
    return idx;
  endfunction

  assign fin_vec = done_i & gnt_q & {N_REQ{busy_q}};
  assign fin     = |fin_vec;
  assign start   = !busy_q && (req_i != '0);
  assign gnt_idx = oh_to_idx(gnt_q);
  assign gnt_o   = gnt_q;

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= ARB_AGE;
    end else if (cfg_we_i && cfg_addr_i == '0) begin
      mode_q <= arb_mode_e'(cfg_wdata_i[0]);
    end
  end

  for (genvar g = 0; g < N_REQ; g++) begin : g_tmo
    if (g == HOST_IDX) begin : g_host
      assign tmo_q[g] = TMO_W'(TMO_RESET);
    end else begin : g_peer
      always_ff @(posedge clk) begin
        if (!rst_n) tmo_q[g] <= TMO_W'(TMO_RESET);
        else if (cfg_we_i && cfg_addr_i == CFG_AW'(g + 1)) tmo_q[g] <= cfg_wdata_i;
      end
    end
  end

  // per-master wait counters; the host has none
  for (genvar g = 0; g < N_REQ; g++) begin : g_wait
    if (g == HOST_IDX) begin : g_host
      assign hi[g] = 1'b0;
    end else begin : g_peer
      arb_wait_ctr #(.TMO_W(TMO_W)) u_ctr (
        .clk   (clk),
        .rst_n (rst_n),
        .req_i (req_i[g]),
        .gnt_i (gnt_q[g]),
        .fin_i (fin_vec[g]),
        .tmo_i (tmo_q[g]),
        .hi_o  (hi[g])
      );
    end
  end

  arb_lru_order #(.N_REQ(N_REQ)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_en_i  (fin),
    .upd_idx_i (gnt_idx),
    .rank_o    (rank)
  );

  arb_pick #(.N_REQ(N_REQ)) u_pick (
    .pend_i (req_i),
    .hi_i   (hi),
    .tier_i (mode_q == ARB_TIER),
    .rank_i (rank),
    .win_o  (win)
  );

  // grant register: issued from idle, held until the owner completes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (fin) begin
      gnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      gnt_q  <= win;
      busy_q <= 1'b1;
    end
  end

  // R1: never more than one grant
  a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt_q));
  // R1: an idle cycle with requests yields a grant to one of them
  a_r1_grant_to_req: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> $onehot(gnt_q) && ((gnt_q & $past(req_i)) != '0));
  // R5: grant frozen until its owner finishes
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !fin) |=> $stable(gnt_q));
  // R5: completion always yields an idle cycle
  a_r5_idle_after_fin: assert property (@(posedge clk) disable iff (!rst_n)
    fin |=> gnt_q == '0);
  // R3: in tiered mode an urgent requester always wins
  a_r3_urgent_first: assert property (@(posedge clk) disable iff (!rst_n)
    (start && mode_q == ARB_TIER && ((req_i & hi) != '0)) |=> (gnt_q & $past(hi)) != '0);
endmodule

// File: tb/mem_lru_arb_tb.sv
module mem_lru_arb_tb;
  localparam int N = 4;
  localparam int TW = 8;
  localparam int AW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  req;
  logic [N-1:0]  done;
  logic          cfg_we;
  logic [AW-1:0] cfg_addr;
  logic [TW-1:0] cfg_wdata;
  logic [N-1:0]  gnt;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  mem_lru_arb #(.N_REQ(N), .TMO_W(TW), .HOST_IDX(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_i(req), .done_i(done),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .gnt_o(gnt));

  task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; req = '0; done = '0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic cfg_write(input int addr, input int data);
    cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_wdata = TW'(data);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // advance until a grant shows, then compare
  task automatic wait_gnt(input string tag, input int exp_idx);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (gnt != '0) break;
    end
    chk(tag, gnt, N'(1) << exp_idx);
  endtask

  // finish the current owner, check the idle cycle
  task automatic finish(input int idx, input string tag);
    done[idx] = 1'b1;
    @(negedge clk);
    done = '0;
    chk(tag, gnt, '0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R8 no grant after reset", gnt, '0);
  endtask

  task automatic t_rotation();
    do_reset();
    req = 4'b1111;
    wait_gnt("R2 rotate 1st", 0); finish(0, "R5 idle after done");
    wait_gnt("R2 rotate 2nd", 1); finish(1, "R5 idle after done");
    wait_gnt("R2 rotate 3rd", 2); finish(2, "R5 idle after done");
    wait_gnt("R2 rotate 4th", 3); finish(3, "R5 idle after done");
    wait_gnt("R2 R7 rotate wraps", 0); finish(0, "R5 idle after done");
    req = '0;
  endtask

  task automatic t_hold();
    do_reset();
    req = 4'b0010;
    wait_gnt("R1 sole requester", 1);
    req = 4'b1111;
    for (int k = 0; k < 5; k++) begin
      if (k == 2) done[2] = 1'b1;
      @(negedge clk);
      done = '0;
      chk("R5 grant held", gnt, 4'b0010);
    end
    finish(1, "R5 idle after owner done");
    wait_gnt("R2 R7 oldest after finish", 0);
    finish(0, "R5 idle");
    req = '0;
  endtask

  task automatic t_tier_promote(input bit tier);
    do_reset();
    cfg_write(1 + 3, 2);
    cfg_write(1 + 1, 50);
    cfg_write(1 + 2, 50);
    cfg_write(0, tier ? 1 : 0);
    req = 4'b0001;
    wait_gnt("R1 host alone", 0);
    req = 4'b1111;
    repeat (4) @(negedge clk);
    finish(0, "R5 idle");
    if (!tier) begin
      wait_gnt("R2 age mode ignores wait", 1);
      finish(1, "R5 idle");
    end else begin
      wait_gnt("R3 R4 R10 promoted wins", 3);
      req[3] = 1'b0;
      finish(3, "R5 idle");
      wait_gnt("R3 normal tier by age", 1);
      req[3] = 1'b1;
      finish(1, "R5 idle");
      wait_gnt("R7 count cleared, no early promotion", 2);
      finish(2, "R5 idle");
    end
    req = '0;
  endtask

  task automatic t_host();
    do_reset();
    cfg_write(1 + 2, 2);
    cfg_write(1 + 0, 1);
    cfg_write(0, 1);
    req = 4'b0010;
    wait_gnt("R1 peer alone", 1);
    req = 4'b0111;
    repeat (8) @(negedge clk);
    finish(1, "R5 idle");
    wait_gnt("R6 host not promoted", 2);
    finish(2, "R5 idle");
    req = '0;
  endtask

  task automatic t_min_tmo();
    do_reset();
    cfg_write(0, 1);
    req = 4'b1000;
    wait_gnt("R1 peer alone", 3);
    req = 4'b1101;
    repeat (3) @(negedge clk);
    finish(3, "R5 idle");
    wait_gnt("R8 limit 1 after reset promotes", 2);
    finish(2, "R5 idle");
    req = '0;
  endtask

  task automatic t_mode_mid_grant();
    do_reset();
    req = 4'b0100;
    wait_gnt("R1 peer alone", 2);
    req = 4'b1111;
    @(negedge clk);
    cfg_write(0, 1);
    chk("R9 grant kept over mode write", gnt, 4'b0100);
    @(negedge clk);
    chk("R9 grant kept after mode write", gnt, 4'b0100);
    finish(2, "R5 idle");
    wait_gnt("R9 new mode at next arbitration", 1);
    finish(1, "R5 idle");
    req = '0;
  endtask

  task automatic t_withdraw();
    do_reset();
    cfg_write(1 + 3, 2);
    cfg_write(0, 1);
    req = 4'b0010;
    wait_gnt("R1 peer alone", 1);
    req = 4'b1010;
    repeat (4) @(negedge clk);
    req = 4'b0010;
    @(negedge clk);
    req = 4'b1011;
    finish(1, "R5 idle");
    wait_gnt("R11 withdrawn request lost urgency", 0);
    finish(0, "R5 idle");
    req = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_rotation();
    t_hold();
    t_tier_promote(1'b1);
    t_tier_promote(1'b0);
    t_host();
    t_min_tmo();
    t_mode_mid_grant();
    t_withdraw();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule